// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a bus target for SMBus. It holds a small configuration register file for a clock buffer. The host reaches it only through indexed block transfers. Every transfer begins with a write-direction address byte and a starting index. A write then gives an explicit byte count and the data bytes, which land at consecutive indexes. A read uses a repeated start and a read-direction address. The target answers with a byte count taken from its count register, then returns register bytes from the index upward until the host refuses a byte.

SCL and SDA are brought into the system clock domain through a short synchroniser. Start and stop conditions and SCL edges are found from the synchronised copies. SDA is driven only as an open-drain pull-down. The target's 7-bit address is one of three values. A three-level strap input picks the value, and the block captures the strap on the first rising edge of the power-good input. Control logic reads the whole register file as a flat vector. A two-bit PLL mode status feeds two read-only bits. A single enable input stands for "reference clock present" and gates the bus engine.

Top module: `smbBlockRegs`

## Requirements
- R1: The address is captured once, on the first rising edge of `pwrGood` after reset. Strap code 0 selects 0x6B, code 1 selects 0x6C, and codes 2 and 3 select 0x6D. Later strap changes or later `pwrGood` edges do not change it. Before the capture, no address is acknowledged.
- R2: If an address byte does not match, it gets no ACK (SDA stays released on the ninth clock). The target then acknowledges nothing and drives nothing until the next start or stop.
- R3: A write is: start, address+W, index N, count X, then data. Each data byte is stored at N, N+1 and so on while fewer than X bytes have been taken. Every byte of a matched write is acknowledged.
- R4: Data bytes beyond the count X are acknowledged and discarded. When X is 0, nothing is stored.
- R5: A read is: start, address+W, index N, repeated start, address+R. The target sends a byte count first, equal to index 7 bits 4:0 with bits 7:5 zero. It then sends the bytes at N, N+1 and so on. After a host ACK it sends the next byte. After a host NACK it releases SDA.
- R6: Reset values as read: index 0 = 0xFF, index 1 = {mode status, 6'b000110}, index 2 = 0xFF, index 3 = 0x07, index 4 = 0xFF, index 5 = 0x01, index 6 = 0x46, index 7 = 0x08.
- R7: Some bits ignore writes but still get an ACK. Indexes 0 and 2: bits 5 and 1 always read 1. Index 1: bit 2 always reads 1, and bits 7:6 show `pllModeSense`. Index 3: bits 7:6 read 0 and bits 2:1 read 1. Indexes 4, 5 and 6: every bit is read-only. Index 7: bits 7:5 read 0.
- R8: Indexes 8 and above read as 0xFF. Writes to them are acknowledged and ignored.
- R9: Start and stop are recognised only from an SDA edge while SCL is high. A repeated start in the middle of a transfer abandons it and begins a new address phase.
- R10: While `busEn` is low, SDA is released and any transfer in progress is abandoned. Register contents are kept.
- R11: `cfgView` byte i (bits 8i+7:8i) always equals what a read of index i would return.
- R12: The target starts pulling SDA low only while SCL is low. Its SDA drive does not change while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busEn | input | 1 | Reference-clock-present enable for the bus engine |
| pwrGood | input | 1 | Power-good; its first rise latches the strap |
| strapLvl | input | 2 | Three-level address strap: 0 low, 1 mid, 2 or 3 high |
| pllModeSense | input | 2 | Active PLL mode, shown in index 1 bits 7:6 |
| sclIn | input | 1 | SMBus clock line as seen on the bus |
| sdaIn | input | 1 | SMBus data line as seen on the bus |
| sdaDrvLow | output | 1 | 1 pulls SDA low (open drain) |
| cfgView | output | 64 | Read view of indexes 0 to 7, byte i at bits 8i+7:8i |

## Verification
The bench attacks count handling in three ways: extra bytes past the count, a count of zero, and a count register written with all ones. A design that ignored the count would corrupt neighbouring registers. A design that failed to mask the count would return a wrong leading byte on reads. Reads that run across the end of the file into indexes 8 and up catch a pointer that wraps or returns stale data. Writes of zeros to read-only and reserved bits catch missing write masks. A repeated start after the count byte, a mismatched address, a strap changed after capture, and `busEn` dropped while the target holds SDA low check that the engine drops state and releases the line when it should, rather than acknowledging for the wrong address or keeping the bus stuck low.

// File: rtl/smbRegPkg.sv
package smbRegPkg;

  localparam int NUM_REGS = 8;
  localparam int MODE_IDX = 1;
  localparam int CNT_IDX  = 7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } busState_t;

  typedef enum logic [1:0] {
    ROLE_ADDR,
    ROLE_INDEX,
    ROLE_COUNT,
    ROLE_DATA
  } byteRole_t;

  // one-cycle requests from the bus engine to the register datapath
  typedef struct packed {
    logic       loadIdx;
    logic       loadCnt;
    logic       wrData;
    logic       advRead;
    logic [7:0] rxByte;
  } dpStrobe_t;

  // bits the host may change
  function automatic logic [7:0] wrMask(input int idx);
    case (idx)
      0, 2:    return 8'hDD;
      1:       return 8'h3B;
      3:       return 8'h39;
      7:       return 8'h1F;
      default: return 8'h00;
    endcase
  endfunction

  // value of the bits the host may not change
  function automatic logic [7:0] fixedBits(input int idx);
    case (idx)
      0, 2:    return 8'h22;
      1:       return 8'h04;
      3:       return 8'h06;
      4:       return 8'hFF;
      5:       return 8'h01;  // revision 0, vendor code 1
      6:       return 8'h46;  // type 01, id 000110
      default: return 8'h00;
    endcase
  endfunction

  // reset value of the writable bits
  function automatic logic [7:0] resetBits(input int idx);
    case (idx)
      0, 2:    return 8'hFF;
      1:       return 8'h02;
      3:       return 8'h01;
      7:       return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/smbBusCtrl.sv
module smbBusCtrl
  import smbRegPkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_LO     = 7'h6B,
  parameter logic [6:0] ADDR_MID    = 7'h6C,
  parameter logic [6:0] ADDR_HI     = 7'h6D
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busEn,
  input  logic       pwrGood,
  input  logic [1:0] strapLvl,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] cntByte,
  input  logic [7:0] rdByte,
  output dpStrobe_t  dpStb,
  output logic       sdaDrvLow
);

  localparam int BIT_W = 4;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(8);

  // input synchronisers
  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclS, sdaS, sclP, sdaP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclP    <= 1'b1;
      sdaP    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclP    <= sclS;
      sdaP    <= sdaS;
    end
  end

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  logic startEv, stopEv, sclRise, sclFall;
  assign startEv = sclS && sclP && sdaP && !sdaS;
  assign stopEv  = sclS && sclP && !sdaP && sdaS;
  assign sclRise = sclS && !sclP;
  assign sclFall = !sclS && sclP;

  // strap capture at the first power-good rise
  function automatic logic [6:0] pickAddr(input logic [1:0] lvl);
    case (lvl)
      2'd0:    return ADDR_LO;
      2'd1:    return ADDR_MID;
      default: return ADDR_HI;
    endcase
  endfunction

  logic       pgQ, captured;
  logic [6:0] myAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgQ      <= 1'b0;
      captured <= 1'b0;
      myAddr   <= '0;
    end else begin
      pgQ <= pwrGood;
      if (pwrGood && !pgQ && !captured) begin
        captured <= 1'b1;
        myAddr   <= pickAddr(strapLvl);
      end
    end
  end

  logic active;
  assign active = busEn && captured;

  // protocol engine
  busState_t        state;
  byteRole_t        role;
  logic [BIT_W-1:0] bitCnt;
  logic [7:0]       shReg, txByte;
  logic             readDir, sdaLowQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      role    <= ROLE_ADDR;
      bitCnt  <= '0;
      shReg   <= '0;
      txByte  <= '0;
      readDir <= 1'b0;
      sdaLowQ <= 1'b0;
      dpStb   <= '0;
    end else begin
      dpStb <= '0;
      if (!active) begin
        state   <= ST_IDLE;
        sdaLowQ <= 1'b0;
      end else if (startEv) begin
        state   <= ST_RX;
        role    <= ROLE_ADDR;
        bitCnt  <= '0;
        readDir <= 1'b0;
        sdaLowQ <= 1'b0;
      end else if (stopEv) begin
        state   <= ST_IDLE;
        sdaLowQ <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise) begin
              shReg  <= {shReg[6:0], sdaS};
              bitCnt <= bitCnt + BIT_W'(1);
            end else if (sclFall && bitCnt == LAST_BIT) begin
              bitCnt <= '0;
              if (role == ROLE_ADDR && shReg[7:1] != myAddr) begin
                state <= ST_SKIP;
              end else begin
                state   <= ST_ACK;
                sdaLowQ <= 1'b1;
                dpStb.rxByte <= shReg;
                case (role)
                  ROLE_ADDR: begin
                    readDir <= shReg[0];
                    role    <= ROLE_INDEX;
                  end
                  ROLE_INDEX: begin
                    dpStb.loadIdx <= 1'b1;
                    role          <= ROLE_COUNT;
                  end
                  ROLE_COUNT: begin
                    dpStb.loadCnt <= 1'b1;
                    role          <= ROLE_DATA;
                  end
                  default: dpStb.wrData <= 1'b1;
                endcase
              end
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (readDir) begin
                state   <= ST_TX;
                txByte  <= cntByte;
                sdaLowQ <= !cntByte[7];
              end else begin
                state   <= ST_RX;
                sdaLowQ <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (sclRise) begin
              bitCnt <= bitCnt + BIT_W'(1);
            end else if (sclFall) begin
              if (bitCnt == LAST_BIT) begin
                state   <= ST_MACK;
                sdaLowQ <= 1'b0;
              end else begin
                sdaLowQ <= !txByte[6];
                txByte  <= {txByte[6:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (sclRise) begin
              if (sdaS) state <= ST_SKIP;
            end else if (sclFall) begin
              state         <= ST_TX;
              bitCnt        <= '0;
              txByte        <= rdByte;
              sdaLowQ       <= !rdByte[7];
              dpStb.advRead <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sdaDrvLow = sdaLowQ;

  assert_sda_rise_scl_low_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaLowQ) |-> !sclS);

  assert_released_when_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE || state == ST_SKIP) |-> !sdaLowQ);

  assert_release_on_disable_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busEn |=> !sdaLowQ);

  assert_addr_locked_R1: assert property (@(posedge clk) disable iff (!rstN)
    captured |=> (captured && $stable(myAddr)));

endmodule

// File: rtl/smbRegData.sv
module smbRegData
  import smbRegPkg::*;
(
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               dpStb,
  input  logic [1:0]              pllModeSense,
  output logic [7:0]              rdByte,
  output logic [7:0]              cntByte,
  output logic [NUM_REGS*8-1:0]   cfgView
);

  localparam int SEL_W = $clog2(NUM_REGS);

  logic [7:0] regQ  [NUM_REGS];
  logic [7:0] viewW [NUM_REGS];
  logic [7:0] ptrQ, remainQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= resetBits(i) & wrMask(i);
      ptrQ    <= '0;
      remainQ <= '0;
    end else begin
      if (dpStb.loadIdx) ptrQ    <= dpStb.rxByte;
      if (dpStb.loadCnt) remainQ <= dpStb.rxByte;
      if (dpStb.advRead) ptrQ    <= ptrQ + 8'd1;
      if (dpStb.wrData && remainQ != 8'd0) begin
        for (int i = 0; i < NUM_REGS; i++) begin
          if (ptrQ == 8'(i))
            regQ[i] <= (regQ[i] & ~wrMask(i)) | (dpStb.rxByte & wrMask(i));
        end
        ptrQ    <= ptrQ + 8'd1;
        remainQ <= remainQ - 8'd1;
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : gView
    localparam logic [7:0] M = wrMask(g);
    localparam logic [7:0] F = fixedBits(g);
    logic [7:0] base;
    assign base = (regQ[g] & M) | (F & ~M);
    if (g == MODE_IDX) begin : gMode
      assign viewW[g] = {pllModeSense, base[5:0]};
    end else begin : gPlain
      assign viewW[g] = base;
    end
    assign cfgView[g*8 +: 8] = viewW[g];
  end

  assign rdByte  = (ptrQ < 8'(NUM_REGS)) ? viewW[ptrQ[SEL_W-1:0]] : 8'hFF;
  assign cntByte = viewW[CNT_IDX];

  assert_count_decrements_R3: assert property (@(posedge clk) disable iff (!rstN)
    (dpStb.wrData && remainQ != 8'd0) |=> (remainQ == $past(remainQ) - 8'd1));

  assert_spent_count_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (dpStb.wrData && remainQ == 8'd0) |=> (remainQ == 8'd0 && $stable(ptrQ)));

endmodule

// File: rtl/smbBlockRegs.sv
module smbBlockRegs
  import smbRegPkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] ADDR_LO     = 7'h6B,
  parameter logic [6:0] ADDR_MID    = 7'h6C,
  parameter logic [6:0] ADDR_HI     = 7'h6D
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busEn,
  input  logic                  pwrGood,
  input  logic [1:0]            strapLvl,
  input  logic [1:0]            pllModeSense,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaDrvLow,
  output logic [NUM_REGS*8-1:0] cfgView
);

  dpStrobe_t  dpStb;
  logic [7:0] rdByte, cntByte;

  smbBusCtrl #(
    .SYNC_STAGES (SYNC_STAGES),
    .ADDR_LO     (ADDR_LO),
    .ADDR_MID    (ADDR_MID),
    .ADDR_HI     (ADDR_HI)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .busEn     (busEn),
    .pwrGood   (pwrGood),
    .strapLvl  (strapLvl),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .cntByte   (cntByte),
    .rdByte    (rdByte),
    .dpStb     (dpStb),
    .sdaDrvLow (sdaDrvLow)
  );

  smbRegData uData (
    .clk          (clk),
    .rstN         (rstN),
    .dpStb        (dpStb),
    .pllModeSense (pllModeSense),
    .rdByte       (rdByte),
    .cntByte      (cntByte),
    .cfgView      (cfgView)
  );

endmodule

// File: tb/tb_smbBlockRegs.sv
module tb_smbBlockRegs;

  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] ADR_LO  = 7'h6B;
  localparam logic [6:0] ADR_MID = 7'h6C;
  localparam logic [6:0] ADR_HI  = 7'h6D;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busEn = 1'b1;
  logic pwrGood = 1'b0;
  logic [1:0] strapLvl = 2'd1;
  logic [1:0] pllModeSense = 2'b10;
  logic sclDrv = 1'b1;
  logic sdaHost = 1'b1;
  logic sdaBus;
  logic sdaDrvLow;
  logic [63:0] cfgView;

  int nChecks = 0;
  int nFail = 0;
  logic cmpOn = 1'b0;
  logic [7:0] mReg [8];

  assign sdaBus = sdaHost & ~sdaDrvLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbBlockRegs dut (
    .clk          (clk),
    .rstN         (rstN),
    .busEn        (busEn),
    .pwrGood      (pwrGood),
    .strapLvl     (strapLvl),
    .pllModeSense (pllModeSense),
    .sclIn        (sclDrv),
    .sdaIn        (sdaBus),
    .sdaDrvLow    (sdaDrvLow),
    .cfgView      (cfgView)
  );

  // ---------------- reference model ----------------
  task automatic modelReset();
    mReg[0] = 8'hFF; mReg[1] = 8'h06; mReg[2] = 8'hFF; mReg[3] = 8'h07;
    mReg[4] = 8'hFF; mReg[5] = 8'h01; mReg[6] = 8'h46; mReg[7] = 8'h08;
  endtask

  task automatic modelWrite(input int idx, input logic [7:0] v);
    case (idx)
      0, 2: mReg[idx] = v | 8'h22;
      1:    mReg[1]   = (v & 8'h3B) | 8'h04;
      3:    mReg[3]   = (v & 8'h39) | 8'h06;
      7:    mReg[7]   = v & 8'h1F;
      default: ;
    endcase
  endtask

  function automatic logic [7:0] expByte(input int i);
    if (i > 7) return 8'hFF;
    if (i == 1) return {pllModeSense, mReg[1][5:0]};
    return mReg[i];
  endfunction

  function automatic logic [63:0] expView();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = expByte(i);
    return v;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R11: register view compared with the model on every clock while idle
  always @(negedge clk) begin
    if (cmpOn) check("R11 cfgView", cfgView, expView());
  end

  // ---------------- bus host ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    sdaHost = 1'b1; sclDrv = 1'b1; tick(Q);
    sdaHost = 1'b0; tick(Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic busRestart();
    sdaHost = 1'b1; tick(Q);
    sclDrv = 1'b1; tick(Q);
    sdaHost = 1'b0; tick(Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaHost = 1'b0; tick(Q);
    sclDrv = 1'b1; tick(Q);
    sdaHost = 1'b1; tick(Q);
  endtask

  task automatic putBit(input logic b);
    sdaHost = b; tick(Q);
    sclDrv = 1'b1; tick(2*Q);
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic getBit(output logic b);
    logic d0;
    sdaHost = 1'b1; tick(Q);
    sclDrv = 1'b1; tick(Q);
    b = sdaBus;
    d0 = sdaDrvLow;
    tick(Q);
    check("R12 drive stable while SCL high", 64'(sdaDrvLow), 64'(d0));
    sclDrv = 1'b0; tick(Q);
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) putBit(b[i]);
    getBit(a);
    ack = !a;
  endtask

  task automatic recvByte(output logic [7:0] b, input logic ackIt);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      getBit(x);
      b[i] = x;
    end
    putBit(!ackIt);
  endtask

  // data bytes: first byte in dat[31:24]
  task automatic doWrite(input logic [6:0] adr, input logic [7:0] idx, input logic [7:0] cnt,
                         input logic [31:0] dat, input int nData, input logic expAck,
                         input string tag);
    logic a;
    cmpOn = 1'b0;
    busStart();
    sendByte({adr, 1'b0}, a); check({tag, " addr ack"}, 64'(a), 64'(expAck));
    sendByte(idx, a);         check({tag, " index ack"}, 64'(a), 64'(expAck));
    sendByte(cnt, a);         check({tag, " count ack"}, 64'(a), 64'(expAck));
    for (int k = 0; k < nData; k++) begin
      sendByte(dat[31-8*k -: 8], a);
      check({tag, " data ack"}, 64'(a), 64'(expAck));
    end
    busStop();
    tick(4);
    if (expAck) begin
      for (int k = 0; k < nData; k++)
        if (k < int'(cnt)) modelWrite(int'(idx) + k, dat[31-8*k -: 8]);
    end
    cmpOn = 1'b1;
  endtask

  task automatic doRead(input logic [6:0] adr, input logic [7:0] idx, input int nData,
                        input string tag);
    logic a;
    logic [7:0] b;
    cmpOn = 1'b0;
    busStart();
    sendByte({adr, 1'b0}, a); check({tag, " addr ack"}, 64'(a), 64'd1);
    sendByte(idx, a);         check({tag, " index ack"}, 64'(a), 64'd1);
    busRestart();
    sendByte({adr, 1'b1}, a); check({tag, " read addr ack"}, 64'(a), 64'd1);
    recvByte(b, 1'b1);
    check({tag, " count byte"}, 64'(b), 64'(expByte(7)));
    for (int k = 0; k < nData; k++) begin
      recvByte(b, k < nData - 1);
      check({tag, " data byte"}, 64'(b), 64'(expByte(int'(idx) + k)));
    end
    busStop();
    tick(4);
    cmpOn = 1'b1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    logic a;
    logic [7:0] b;
    modelReset();
    tick(5);
    rstN = 1'b1;
    tick(5);

    // R6 reset contents, line released
    check("R6 reset view", cfgView, expView());
    check("R12 idle release", 64'(sdaDrvLow), 64'd0);
    cmpOn = 1'b1;

    // R1 nothing acknowledged before capture
    doWrite(ADR_MID, 8'd0, 8'd1, 32'h0000_0000, 1, 1'b0, "R1 before capture");

    // R1 capture mid strap, then later strap and pwrGood changes are ignored
    pwrGood = 1'b1; tick(4);
    strapLvl = 2'd0; tick(4);
    pwrGood = 1'b0; tick(4);
    pwrGood = 1'b1; tick(4);

    // R2 mismatched address: nothing acked, nothing stored
    doWrite(ADR_LO, 8'd0, 8'd2, 32'h0000_0000, 2, 1'b0, "R2 mismatch");

    // R3 + R7 write two bytes of zeros at index 0
    doWrite(ADR_MID, 8'd0, 8'd2, 32'h0000_0000, 2, 1'b1, "R3 block write");
    check("R7 index0 reserved bits", 64'(cfgView[7:0]), 64'h22);

    // R4 bytes past count are discarded
    doWrite(ADR_MID, 8'd2, 8'd1, 32'h0000_0000, 3, 1'b1, "R4 past count");
    check("R4 index3 untouched", 64'(cfgView[31:24]), 64'h07);

    // R4 zero count stores nothing
    doWrite(ADR_MID, 8'd3, 8'd0, 32'h0000_0000, 1, 1'b1, "R4 zero count");
    check("R4 zero count index3", 64'(cfgView[31:24]), 64'h07);

    // R7 count register keeps only five bits
    doWrite(ADR_MID, 8'd7, 8'd1, 32'hFF00_0000, 1, 1'b1, "R7 count mask");
    check("R7 index7 masked", 64'(cfgView[63:56]), 64'h1F);

    // R5 + R8 read across the end of the file
    doRead(ADR_MID, 8'd5, 5, "R5 R8 read past end");

    // R7 read-only indexes, R8 out-of-range writes
    doWrite(ADR_MID, 8'd4, 8'd3, 32'h0000_0000, 3, 1'b1, "R7 read-only write");
    doWrite(ADR_MID, 8'd9, 8'd2, 32'h0011_0000, 2, 1'b1, "R8 out of range write");

    // R5 read from index 0 with a count of 3
    doWrite(ADR_MID, 8'd7, 8'd1, 32'h0300_0000, 1, 1'b1, "R5 set count");
    doRead(ADR_MID, 8'd0, 3, "R5 read from 0");

    // R7 / R11 mode status shows in index 1
    cmpOn = 1'b0;
    pllModeSense = 2'b01;
    tick(2);
    check("R7 mode bits", 64'(cfgView[15:14]), 64'h1);
    cmpOn = 1'b1;
    doRead(ADR_MID, 8'd1, 1, "R7 mode readback");

    // R9 repeated start abandons a write after its count byte
    cmpOn = 1'b0;
    busStart();
    sendByte({ADR_MID, 1'b0}, a); check("R9 first addr ack", 64'(a), 64'd1);
    sendByte(8'd0, a);
    sendByte(8'd1, a);
    busRestart();
    sendByte({ADR_MID, 1'b0}, a); check("R9 restart addr ack", 64'(a), 64'd1);
    sendByte(8'd3, a);
    sendByte(8'd1, a);
    sendByte(8'h00, a);          check("R9 data ack", 64'(a), 64'd1);
    busStop();
    tick(4);
    modelWrite(3, 8'h00);
    cmpOn = 1'b1;
    tick(2);
    check("R9 index0 kept", 64'(cfgView[7:0]), 64'h22);
    check("R9 index3 written", 64'(cfgView[31:24]), 64'h06);

    // R10 disable while the target holds SDA low
    cmpOn = 1'b0;
    busStart();
    sendByte({ADR_MID, 1'b0}, a);
    sendByte(8'd0, a);
    busRestart();
    sendByte({ADR_MID, 1'b1}, a); check("R5 read addr ack", 64'(a), 64'd1);
    check("R5 count msb driven", 64'(sdaDrvLow), 64'd1);
    busEn = 1'b0;
    tick(4);
    check("R10 released on disable", 64'(sdaDrvLow), 64'd0);
    busEn = 1'b1;
    busStop();
    tick(4);
    cmpOn = 1'b1;
    doRead(ADR_MID, 8'd0, 1, "R10 after re-enable");

    // R1 high strap code 3 after a fresh reset, R6 again
    cmpOn = 1'b0;
    rstN = 1'b0;
    pwrGood = 1'b0;
    strapLvl = 2'd3;
    tick(4);
    modelReset();
    rstN = 1'b1;
    tick(4);
    check("R6 reset view again", cfgView, expView());
    pwrGood = 1'b1;
    tick(4);
    cmpOn = 1'b1;
    doWrite(ADR_MID, 8'd0, 8'd1, 32'h0000_0000, 1, 1'b0, "R1 old address");
    doWrite(ADR_HI, 8'd0, 8'd1, 32'h8000_0000, 1, 1'b1, "R1 high strap");
    check("R1 high strap stored", 64'(cfgView[7:0]), 64'hA2);

    cmpOn = 1'b0;
    tick(4);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule